// File: doc/BRIEF.md
# Maskable Fault Aggregation Controller

This block gathers raw fault events from a set of fault groups (cell undervoltage and overvoltage, temperature limits, general-purpose inputs, communication links, one-time-programmable memory, supply rails, system checks and built-in self-test). Each group owns an 8-bit sticky status register and an 8-bit mask register. A raw event always sets its status bit, whatever the mask says. Masking only decides whether the bit contributes to the group summary, the active-low fault pin, the daisy-chain fault-tone request and the stop request sent to cell balancing.

A host reaches the registers through a synchronous read/write port that selects a group index and a register kind. Status bits are cleared by writing ones. Mask registers are plain read/write. Summary bits are read-only and packed eight groups per read word. Because the outputs are computed combinationally from registered status and mask, writing a mask bit over an active fault releases the pin straight after the write edge.

Top module: `fault_agg_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status and mask bit clears. After that edge `fault_n` is 1, `tone_req` and `bal_stop` are 0 and `rdata` is 0.
- R2: A 1 on `raw_fault[g*8+b]` at an edge sets status bit b of group g at that edge, whether or not the bit is masked. The bit stays set after the raw input returns to 0.
- R3: A write with `reg_sel`=2'b00 clears each status bit of group `grp_idx` where `wdata` holds a 1. Bits written with 0 keep their value.
- R4: When a raw event and a clear hit the same status bit at the same edge, the bit stays set.
- R5: A write with `reg_sel`=2'b01 loads `wdata` into the mask register of group `grp_idx`. A 1 in a mask bit masks that fault.
- R6: Summary bit g is the OR of the status bits of group g that are not masked. A read with `reg_sel`=2'b10 returns summary bits `grp_idx*8` to `grp_idx*8+7` in rdata bits 0 to 7, with 0 above the last group.
- R7: `fault_n` is 0 exactly when some summary bit is 1. `tone_req` is the inverse of `fault_n`.
- R8: Setting the mask bit of the only active fault drives `fault_n` high right after the write edge, with no other host action. Clearing that mask bit again drives it low while the status bit is still set.
- R9: `bal_stop` is 1 exactly when `bal_on` is 1 and some unmasked status bit is set. Masked faults never raise it.
- R10: A read (`rd_en`=1) returns the register value as it was before that edge on `rdata` right after the edge. `rdata` holds its value while `rd_en` is 0.
- R11: Writes to a group index at or above the number of groups, or with `reg_sel`=2'b10 or 2'b11, change nothing. Reads of such a group, or with `reg_sel`=2'b11, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_fault | input | NUM_GROUPS*GRP_W | Raw fault events, group g in bits g*8 upward |
| bal_on | input | 1 | Cell balancing currently running |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| grp_idx | input | GIDX_W | Group index, or summary bank for summary reads |
| reg_sel | input | 2 | 00 status, 01 mask, 10 summary, 11 reserved |
| wdata | input | GRP_W | Write data |
| rdata | output | GRP_W | Registered read data |
| fault_n | output | 1 | Fault pin, low while an unmasked fault is held |
| tone_req | output | 1 | Daisy-chain fault-tone request |
| bal_stop | output | 1 | Request to stop cell balancing |

## Verification
The hardest case to reach from the ports is a status clear and a raw event on the same bit at the same edge. The bench arranges it with one task that drives the write strobe and the raw vector in the same low phase, with a second bit in the same write that has no raw event, so that the clear is shown to work. Releasing the pin through a mask write needs a fault that is latched and asserting first. The stimulus creates that fault and enables balancing, then writes the mask and samples the pin, the tone and the stop request at the next falling edge.

// File: rtl/fault_agg_pkg.sv
// Package: shared encodings for the fault aggregation controller.
// Assumes a two-bit register selector on the host port.
package fault_agg_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'b00,
        SEL_MASK    = 2'b01,
        SEL_SUMMARY = 2'b10,
        SEL_RSVD    = 2'b11
    } reg_sel_e;

endpackage

// File: rtl/fault_status_bank.sv
// Module: sticky status register for one fault group.
// Raw events set bits; host write-one-to-clear removes them; an event on
// the same edge as a clear keeps the bit set. Raw inputs are synchronous.
module fault_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status
);

    logic [W-1:0] status_nxt;

    // Next state: clear selected bits, then OR in new events so they win.
    always_comb begin
        status_nxt = status;
        if (clr_we) begin
            status_nxt = status & ~clr_bits;
        end
        status_nxt = status_nxt | raw;
    end

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_nxt;
        end
    end

endmodule

// File: rtl/fault_mask_bank.sv
// Module: host-written mask register for one fault group.
// A 1 masks the matching fault; reset leaves every fault unmasked.
module fault_mask_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    // Mask register: loads on write strobe, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (we) begin
            mask <= wdata;
        end
    end

endmodule

// File: rtl/fault_summary.sv
// Module: per-group summary and output gating.
// Purely combinational from registered status and mask, so a mask write
// takes effect on the outputs right after its edge.
module fault_summary #(
    parameter int NG = 10,
    parameter int W  = 8
) (
    input  logic [NG*W-1:0] status_flat,
    input  logic [NG*W-1:0] mask_flat,
    input  logic            bal_on,
    output logic [NG-1:0]   summary,
    output logic            fault_n,
    output logic            tone_req,
    output logic            bal_stop
);

    logic any_fault;

    // One summary bit per group: any unmasked status bit.
    for (genvar g = 0; g < NG; g++) begin : g_sum
        assign summary[g] = |(status_flat[g*W +: W] & ~mask_flat[g*W +: W]);
    end

    // Output gating derived from the summary vector.
    always_comb begin
        any_fault = |summary;
        fault_n   = ~any_fault;
        tone_req  = any_fault;
        bal_stop  = any_fault & bal_on;
    end

endmodule

// File: rtl/fault_regport.sv
// Module: host register port decode and registered read mux.
// Assumes single-cycle strobes; reads return pre-edge values one cycle later.
module fault_regport
    import fault_agg_pkg::*;
#(
    parameter int NG     = 10,
    parameter int W      = 8,
    parameter int GIDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [GIDX_W-1:0] grp_idx,
    input  logic [1:0]      reg_sel,
    input  logic [W-1:0]    wdata,
    input  logic [NG*W-1:0] status_flat,
    input  logic [NG*W-1:0] mask_flat,
    input  logic [NG-1:0]   summary,
    output logic [NG-1:0]   clr_we,
    output logic [NG-1:0]   mask_we,
    output logic [W-1:0]    rdata
);

    localparam int NBANK = (NG + W - 1) / W;
    localparam int SPADW = NBANK * W;

    reg_sel_e          sel;
    logic [SPADW-1:0]  sum_pad;
    logic [W-1:0]      rd_mux;

    assign sel     = reg_sel_e'(reg_sel);
    assign sum_pad = SPADW'(summary);

    // Write strobes per group; out-of-range index hits no group.
    for (genvar g = 0; g < NG; g++) begin : g_dec
        assign clr_we[g]  = wr_en && (sel == SEL_STATUS) && (int'(grp_idx) == g);
        assign mask_we[g] = wr_en && (sel == SEL_MASK)   && (int'(grp_idx) == g);
    end

    // Read mux: pick status, mask or summary bank; zero otherwise.
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_STATUS: begin
                for (int g = 0; g < NG; g++) begin
                    if (int'(grp_idx) == g) rd_mux = status_flat[g*W +: W];
                end
            end
            SEL_MASK: begin
                for (int g = 0; g < NG; g++) begin
                    if (int'(grp_idx) == g) rd_mux = mask_flat[g*W +: W];
                end
            end
            SEL_SUMMARY: begin
                for (int b = 0; b < NBANK; b++) begin
                    if (int'(grp_idx) == b) rd_mux = sum_pad[b*W +: W];
                end
            end
            default: rd_mux = '0;
        endcase
    end

    // Read data register: updates on read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/fault_agg_ctrl.sv
// Module: top of the maskable fault aggregation controller.
// Holds one status and one mask bank per group, summary gating and the
// host port. Raw fault inputs must already be synchronous to clk.
module fault_agg_ctrl #(
    parameter int NUM_GROUPS = 10,
    parameter int GRP_W      = 8,
    parameter int GIDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*GRP_W-1:0] raw_fault,
    input  logic                        bal_on,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [GIDX_W-1:0]           grp_idx,
    input  logic [1:0]                  reg_sel,
    input  logic [GRP_W-1:0]            wdata,
    output logic [GRP_W-1:0]            rdata,
    output logic                        fault_n,
    output logic                        tone_req,
    output logic                        bal_stop
);

    localparam int FLAT_W = NUM_GROUPS * GRP_W;

    logic [FLAT_W-1:0]     status_flat;
    logic [FLAT_W-1:0]     mask_flat;
    logic [NUM_GROUPS-1:0] summary;
    logic [NUM_GROUPS-1:0] clr_we;
    logic [NUM_GROUPS-1:0] mask_we;

    // Host port: decode and read path.
    fault_regport #(
        .NG(NUM_GROUPS), .W(GRP_W), .GIDX_W(GIDX_W)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .grp_idx(grp_idx), .reg_sel(reg_sel), .wdata(wdata),
        .status_flat(status_flat), .mask_flat(mask_flat), .summary(summary),
        .clr_we(clr_we), .mask_we(mask_we), .rdata(rdata)
    );

    // One status bank and one mask bank per fault group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        fault_status_bank #(.W(GRP_W)) u_stat (
            .clk(clk), .rst_n(rst_n),
            .raw(raw_fault[g*GRP_W +: GRP_W]),
            .clr_we(clr_we[g]), .clr_bits(wdata),
            .status(status_flat[g*GRP_W +: GRP_W])
        );
        fault_mask_bank #(.W(GRP_W)) u_mask (
            .clk(clk), .rst_n(rst_n),
            .we(mask_we[g]), .wdata(wdata),
            .mask(mask_flat[g*GRP_W +: GRP_W])
        );
    end

    // Summary and output gating.
    fault_summary #(.NG(NUM_GROUPS), .W(GRP_W)) u_sum (
        .status_flat(status_flat), .mask_flat(mask_flat), .bal_on(bal_on),
        .summary(summary), .fault_n(fault_n), .tone_req(tone_req),
        .bal_stop(bal_stop)
    );

endmodule

// File: rtl/fault_agg_chk.sv
// Module: assertion checker bound to fault_agg_ctrl.
// Observes ports plus the flattened status and mask registers.
module fault_agg_chk #(
    parameter int NG     = 10,
    parameter int GW     = 8,
    parameter int GIDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NG*GW-1:0]  raw_fault,
    input logic              bal_on,
    input logic              wr_en,
    input logic              rd_en,
    input logic [GIDX_W-1:0] grp_idx,
    input logic [1:0]        reg_sel,
    input logic [GW-1:0]     wdata,
    input logic [GW-1:0]     rdata,
    input logic              fault_n,
    input logic              tone_req,
    input logic              bal_stop,
    input logic [NG*GW-1:0]  status_flat,
    input logic [NG*GW-1:0]  mask_flat
);

    logic [NG*GW-1:0] clr_pos;
    logic [NG*GW-1:0] mwe_pos;
    logic [NG*GW-1:0] mdat_pos;

    // Place the host write at its group position for status and mask writes.
    always_comb begin
        clr_pos  = '0;
        mwe_pos  = '0;
        mdat_pos = '0;
        for (int g = 0; g < NG; g++) begin
            if (wr_en && int'(grp_idx) == g) begin
                if (reg_sel == 2'b00) clr_pos[g*GW +: GW] = wdata;
                if (reg_sel == 2'b01) begin
                    mwe_pos[g*GW +: GW]  = '1;
                    mdat_pos[g*GW +: GW] = wdata;
                end
            end
        end
    end

    assert_reset_outputs_R1: assert property (@(posedge clk)
        !rst_n |=> (fault_n && !tone_req && !bal_stop && rdata == '0));

    assert_raw_sets_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|raw_fault) |=> ((status_flat & $past(raw_fault)) == $past(raw_fault)));

    // R3 and R4: cleared bits without a same-edge event end up zero
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_pos & ~raw_fault)) |=> ((status_flat & $past(clr_pos & ~raw_fault)) == '0));

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|mwe_pos) |=> ((mask_flat & $past(mwe_pos)) == $past(mdat_pos)));

    assert_tone_tracks_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tone_req == !fault_n);

    assert_masked_pin_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flat & ~mask_flat) == '0) |-> fault_n);

    assert_masked_no_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flat & ~mask_flat) == '0 || !bal_on) |-> !bal_stop);

    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind fault_agg_ctrl fault_agg_chk #(
    .NG(NUM_GROUPS), .GW(GRP_W), .GIDX_W(GIDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .raw_fault(raw_fault), .bal_on(bal_on),
    .wr_en(wr_en), .rd_en(rd_en), .grp_idx(grp_idx), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .fault_n(fault_n), .tone_req(tone_req),
    .bal_stop(bal_stop), .status_flat(status_flat), .mask_flat(mask_flat)
);

// File: tb/fault_agg_ctrl_tb.sv
// Bench: scoreboard of expected read data plus direct pin checks.
module fault_agg_ctrl_tb;

    localparam int NG  = 10;
    localparam int GW  = 8;
    localparam int GIW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NG*GW-1:0] raw_fault = '0;
    logic            bal_on = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [GIW-1:0]  grp_idx = '0;
    logic [1:0]      reg_sel = 2'b00;
    logic [GW-1:0]   wdata = '0;
    logic [GW-1:0]   rdata;
    logic            fault_n, tone_req, bal_stop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [GW-1:0] st [NG];
    logic [GW-1:0] mk [NG];

    logic [GW-1:0] exp_q [$];
    string         tag_q [$];
    bit            rd_seen = 1'b0;

    fault_agg_ctrl #(.NUM_GROUPS(NG), .GRP_W(GW), .GIDX_W(GIW)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_fault(raw_fault), .bal_on(bal_on),
        .wr_en(wr_en), .rd_en(rd_en), .grp_idx(grp_idx), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .fault_n(fault_n), .tone_req(tone_req),
        .bal_stop(bal_stop)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [GW-1:0] act, input logic [GW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit any_unmasked();
        for (int g = 0; g < NG; g++) if ((st[g] & ~mk[g]) != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_pins(input string tag);
        bit a;
        a = any_unmasked();
        check({7'b0, fault_n},  {7'b0, ~a}, {tag, " fault_n"});
        check({7'b0, tone_req}, {7'b0, a},  {tag, " tone_req"});
        check({7'b0, bal_stop}, {7'b0, a & bal_on}, {tag, " bal_stop"});
    endtask

    function automatic logic [GW-1:0] model_read(input int g, input logic [1:0] s);
        logic [GW-1:0] v;
        v = '0;
        case (s)
            2'b00: if (g < NG) v = st[g];
            2'b01: if (g < NG) v = mk[g];
            2'b10: for (int j = 0; j < GW; j++)
                       if (g*GW + j < NG) v[j] = ((st[g*GW+j] & ~mk[g*GW+j]) != 0);
            default: v = '0;
        endcase
        return v;
    endfunction

    // Driver: push expected read data, then strobe the read.
    task automatic do_read(input int g, input logic [1:0] s, input string tag);
        exp_q.push_back(model_read(g, s));
        tag_q.push_back(tag);
        grp_idx = GIW'(g); reg_sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input int g, input logic [1:0] s, input logic [GW-1:0] d,
                            input logic [GW-1:0] raw_same);
        grp_idx = GIW'(g); reg_sel = s; wdata = d; wr_en = 1'b1;
        if (g < NG) raw_fault[g*GW +: GW] = raw_same;
        @(negedge clk);
        wr_en = 1'b0; raw_fault = '0;
        if (g < NG && s == 2'b00) st[g] = (st[g] & ~d) | raw_same;
        else if (g < NG) st[g] = st[g] | raw_same;
        if (g < NG && s == 2'b01) mk[g] = d;
    endtask

    task automatic pulse(input int g, input logic [GW-1:0] bits);
        raw_fault[g*GW +: GW] = bits;
        @(negedge clk);
        raw_fault = '0;
        st[g] = st[g] | bits;
    endtask

    // Monitor: note a read at the edge, compare at the following falling edge.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        for (int g = 0; g < NG; g++) begin st[g] = '0; mk[g] = '0; end
        raw_fault = '1;
        repeat (3) @(negedge clk);
        raw_fault = '0;
        @(negedge clk);
        check_pins("R1 reset");
        check(rdata, 8'h00, "R1 rdata reset");
        rst_n = 1'b1;
        @(negedge clk);
        do_read(3, 2'b00, "R1 status after reset");
        do_read(3, 2'b01, "R1 mask after reset");

        pulse(1, 8'h08);
        check_pins("R7 unmasked fault");
        @(negedge clk);
        do_read(1, 2'b00, "R2 sticky status");
        bal_on = 1'b1;
        @(negedge clk);
        check_pins("R9 stop with unmasked fault");

        do_write(1, 2'b01, 8'h08, 8'h00);
        check_pins("R8 mask releases pin");
        check({7'b0, bal_stop}, 8'h00, "R9 masked fault no stop");
        do_read(1, 2'b00, "R2 status kept under mask");
        do_read(1, 2'b01, "R5 mask readback");

        pulse(1, 8'h08);
        check_pins("R8 masked event pin high");
        pulse(2, 8'h81);
        check_pins("R7 second group fault");
        do_read(0, 2'b10, "R6 summary bank0");
        do_read(1, 2'b10, "R6 summary bank1 empty");

        do_write(2, 2'b00, 8'h01, 8'h00);
        do_read(2, 2'b00, "R3 partial clear");
        check_pins("R3 pin after partial clear");
        do_write(2, 2'b00, 8'h80, 8'h00);
        check_pins("R3 pin after full clear");

        pulse(5, 8'h03);
        do_write(5, 2'b00, 8'h03, 8'h01);
        do_read(5, 2'b00, "R4 event wins over clear");

        do_write(12, 2'b01, 8'hFF, 8'h00);
        do_write(2, 2'b10, 8'hFF, 8'h00);
        do_write(2, 2'b11, 8'hFF, 8'h00);
        do_read(2, 2'b01, "R11 mask untouched");
        do_read(12, 2'b00, "R11 out of range read");
        do_read(1, 2'b11, "R11 reserved read");
        check_pins("R11 pins after ignored writes");

        pulse(9, 8'h40);
        do_read(1, 2'b10, "R6 summary bank1 group9");
        repeat (3) @(negedge clk);
        check(rdata, 8'h02, "R10 rdata holds");

        do_write(5, 2'b00, 8'h01, 8'h00);
        do_write(9, 2'b01, 8'h40, 8'h00);
        check_pins("R8 all masked or cleared");
        do_write(1, 2'b01, 8'h00, 8'h00);
        check_pins("R8 unmask reasserts pin");
        bal_on = 1'b0;
        @(negedge clk);
        check_pins("R9 balancing off");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule